// File: doc/BRIEF.md
# Triple-Copy RAM with Background Scrub

This block keeps three identical copies of a small RAM and shows them to a processor bus as one read/write port. Each copy has two ports. The first port of every copy is tied to the user port. A user write goes into all three copies at once. A user read returns the bitwise majority of the three copies, so an upset in any one copy is masked.

The second port of every copy belongs to a scrub engine, which runs without stopping. It holds a scrub address and walks the whole memory. It reads the three copies at that address, votes them, and in the next cycle writes the voted word back into all three copies. Upsets are therefore repaired before a second one can land in the same word.

The scrubber never competes with the processor. If the user port is active in a cycle where the scrubber would start a read, that address is skipped. If the user touches the address whose write-back is pending, that write-back is dropped. The voters are 16 bits wide, and wider words use several of them side by side. A mismatch output pulses whenever a vote has to out-rule a copy.

Top module: `tmr_scrub_ram`

## Requirements
- R1: While reset is held and in the first cycle after it, `usr_rvalid` and `mismatch` are 0, and the scrub address starts at 0.
- R2: A user write (`usr_req`=1, `usr_we`=1) stores `usr_wdata` into all three copies at `usr_addr` in the same cycle. A later read of that address returns the data with `mismatch`=0.
- R3: A user read (`usr_req`=1, `usr_we`=0) raises `usr_rvalid` exactly one cycle later. In that cycle `usr_rdata` is the bitwise majority of the three copies, voted separately in 16-bit slices.
- R4: In the `usr_rvalid` cycle of a user read, `mismatch` is 1 if any copy differs from the voted word at that address.
- R5: In a cycle where the user port is idle and the scrubber is in its read phase, the three copies at the scrub address are read. In the next cycle the voted word is written into all three copies there. The scrub address advances at that write cycle.
- R6: In a cycle where the scrubber is in its read phase and the user port is active, no scrub read occurs and the scrub address advances by one. Under continuous user traffic a corrupted copy is therefore left untouched.
- R7: If the user port accesses the scrub address during the write cycle, the pending scrub write-back is cancelled. A user write in that cycle therefore keeps its own data.
- R8: During a scrub write cycle, `mismatch` is 1 if any copy read in the preceding read cycle differed from the voted word.
- R9: The scrub address wraps from the last address to 0. With the user port idle for 2×DEPTH cycles, every single-copy upset in the memory is repaired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| usr_req | input | 1 | User access strobe for this cycle |
| usr_we | input | 1 | 1 = write, 0 = read (valid with `usr_req`) |
| usr_addr | input | ADDR_W | User word address |
| usr_wdata | input | DATA_W | User write data |
| usr_rdata | output | DATA_W | Voted read data, valid while `usr_rvalid` is 1 |
| usr_rvalid | output | 1 | Read data valid, one cycle after a read request |
| mismatch | output | 1 | Pulses when a user read or a scrub read found a disagreeing copy |

## Verification
The bound checker watches the handshake timing on every cycle. It checks that read-valid follows a read request by exactly one cycle and that the scrubber never reads while the user port is busy. It also checks that every scrub write-back is preceded by a scrub read, that the scrub address steps by one and wraps, and that a mismatch appears only when a vote is actually taking place. Only the bench scenarios can show the data side. Injected single-bit upsets in one copy are voted out on reads. A fault survives a long burst of user traffic and is repaired after one idle pass. Two faults in different copies and different slices are still outvoted, and a cancelled write-back leaves a corrupted copy in place. A user write racing the write-back keeps its own data.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int VOTE_W = 16;

    typedef logic [VOTE_W-1:0] vote_t;

    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } scrub_ph_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } port_op_t;

    function automatic vote_t maj3(vote_t a, vote_t b, vote_t c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/tsr_bank.sv
module tsr_bank #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  tsr_pkg::port_op_t b_op,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_en && a_we)  mem[a_addr] <= a_wdata;
        if (a_en && !a_we) a_rdata     <= mem[a_addr];
        if (b_op.wr)       mem[b_addr] <= b_wdata;
        if (b_op.rd)       b_rdata     <= mem[b_addr];
    end
endmodule

// File: rtl/tsr_voter.sv
module tsr_vote_slice (
    input  tsr_pkg::vote_t a,
    input  tsr_pkg::vote_t b,
    input  tsr_pkg::vote_t c,
    output tsr_pkg::vote_t y,
    output logic           dis
);
    always_comb begin
        y   = tsr_pkg::maj3(a, b, c);
        dis = |((a ^ y) | (b ^ y) | (c ^ y));
    end
endmodule

module tsr_voter #(
    parameter int DATA_W = 32,
    localparam int SLICES = DATA_W / tsr_pkg::VOTE_W
) (
    input  logic [DATA_W-1:0] cp0,
    input  logic [DATA_W-1:0] cp1,
    input  logic [DATA_W-1:0] cp2,
    output logic [DATA_W-1:0] voted,
    output logic              disagree
);
    localparam int VW = tsr_pkg::VOTE_W;
    logic [SLICES-1:0] dis_s;

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        tsr_vote_slice u_slice (
            .a   (cp0[s*VW +: VW]),
            .b   (cp1[s*VW +: VW]),
            .c   (cp2[s*VW +: VW]),
            .y   (voted[s*VW +: VW]),
            .dis (dis_s[s])
        );
    end

    assign disagree = |dis_s;
endmodule

// File: rtl/tsr_scrub_ctl.sv
module tsr_scrub_ctl #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_req,
    input  logic [ADDR_W-1:0] usr_addr,
    output logic [ADDR_W-1:0] sb_addr,
    output tsr_pkg::port_op_t sb_op,
    output logic              sb_in_write
);
    import tsr_pkg::*;

    scrub_ph_e         ph_q;
    logic [ADDR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_READ;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_READ: begin
                    if (usr_req) cnt_q <= cnt_q + 1'b1;
                    else         ph_q  <= PH_WRITE;
                end
                PH_WRITE: begin
                    cnt_q <= cnt_q + 1'b1;
                    ph_q  <= PH_READ;
                end
                default: ph_q <= PH_READ;
            endcase
        end
    end

    always_comb begin
        sb_addr     = cnt_q;
        sb_in_write = (ph_q == PH_WRITE);
        sb_op.rd    = (ph_q == PH_READ) && !usr_req;
        sb_op.wr    = (ph_q == PH_WRITE) && !(usr_req && (usr_addr == cnt_q));
    end
endmodule

// File: rtl/tmr_scrub_ram.sv
module tmr_scrub_ram #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_req,
    input  logic              usr_we,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_wdata,
    output logic [DATA_W-1:0] usr_rdata,
    output logic              usr_rvalid,
    output logic              mismatch
);
    localparam int COPIES = 3;

    tsr_pkg::port_op_t sb_op;
    logic [ADDR_W-1:0] sb_addr;
    logic              sb_in_write;
    logic              sb_rd;
    logic              sb_we;
    logic [DATA_W-1:0] rd_a [COPIES];
    logic [DATA_W-1:0] rd_b [COPIES];
    logic [DATA_W-1:0] sb_voted;
    logic              dis_a;
    logic              dis_b;
    logic              rvalid_q;

    tsr_scrub_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .usr_req     (usr_req),
        .usr_addr    (usr_addr),
        .sb_addr     (sb_addr),
        .sb_op       (sb_op),
        .sb_in_write (sb_in_write)
    );

    for (genvar k = 0; k < COPIES; k++) begin : g_bank
        tsr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .a_en    (usr_req),
            .a_we    (usr_we),
            .a_addr  (usr_addr),
            .a_wdata (usr_wdata),
            .a_rdata (rd_a[k]),
            .b_op    (sb_op),
            .b_addr  (sb_addr),
            .b_wdata (sb_voted),
            .b_rdata (rd_b[k])
        );
    end

    tsr_voter #(.DATA_W(DATA_W)) u_vote_usr (
        .cp0 (rd_a[0]), .cp1 (rd_a[1]), .cp2 (rd_a[2]),
        .voted (usr_rdata), .disagree (dis_a)
    );

    tsr_voter #(.DATA_W(DATA_W)) u_vote_scrub (
        .cp0 (rd_b[0]), .cp1 (rd_b[1]), .cp2 (rd_b[2]),
        .voted (sb_voted), .disagree (dis_b)
    );

    always_ff @(posedge clk) begin
        if (rst) rvalid_q <= 1'b0;
        else     rvalid_q <= usr_req && !usr_we;
    end

    assign sb_rd      = sb_op.rd;
    assign sb_we      = sb_op.wr;
    assign usr_rvalid = rvalid_q;
    assign mismatch   = (rvalid_q && dis_a) || (sb_in_write && dis_b);
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              usr_req,
    input logic              usr_we,
    input logic [ADDR_W-1:0] usr_addr,
    input logic              usr_rvalid,
    input logic              mismatch,
    input logic [ADDR_W-1:0] sb_addr,
    input logic              sb_rd,
    input logic              sb_we,
    input logic              sb_in_write
);
    AST_RESET_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sb_addr == '0 && !usr_rvalid)); // R1

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        (usr_req && !usr_we) |=> usr_rvalid); // R3

    AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        !(usr_req && !usr_we) |=> !usr_rvalid); // R3

    AST_MISMATCH_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> (usr_rvalid || sb_in_write)); // R4

    AST_WRITEBACK_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
        sb_rd |=> sb_in_write); // R5

    AST_WRITEBACK_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        sb_we |-> $past(sb_rd)); // R5

    AST_SCRUB_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!sb_in_write && !usr_req) |=> $stable(sb_addr)); // R5

    AST_SCRUB_YIELDS: assert property (@(posedge clk) disable iff (rst)
        usr_req |-> !sb_rd); // R6

    AST_NO_WRITE_COLLISION: assert property (@(posedge clk) disable iff (rst)
        (sb_we && usr_req) |-> (usr_addr != sb_addr)); // R7

    AST_SCRUB_ADDR_STEPS: assert property (@(posedge clk) disable iff (rst)
        (sb_in_write || usr_req) |=> sb_addr == ADDR_W'($past(sb_addr) + 1'b1)); // R9
endmodule

bind tmr_scrub_ram tsr_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .usr_req     (usr_req),
    .usr_we      (usr_we),
    .usr_addr    (usr_addr),
    .usr_rvalid  (usr_rvalid),
    .mismatch    (mismatch),
    .sb_addr     (sb_addr),
    .sb_rd       (sb_rd),
    .sb_we       (sb_we),
    .sb_in_write (sb_in_write)
);

// File: tb/tmr_scrub_ram_tb_top.sv
module tmr_scrub_ram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int DW = 32;
    localparam int D  = 1 << AW;
    localparam int PASS_CYC = 2 * D + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          we  = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          mm;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    // behavioural model state
    logic [DW-1:0] sh [3][D];
    int            m_ph = 0;
    int            m_cnt = 0;
    logic [DW-1:0] m_sbw = '0;
    bit            m_mmb = 1'b0;
    bit            e_rvalid = 1'b0;
    bit            e_mma = 1'b0;
    logic [DW-1:0] e_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_scrub_ram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .usr_req(req), .usr_we(we), .usr_addr(addr),
        .usr_wdata(wdata), .usr_rdata(rdata), .usr_rvalid(rvalid), .mismatch(mm)
    );

    function automatic logic [DW-1:0] vote(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = (int'(a[i]) + int'(b[i]) + int'(c[i])) >= 2;
        return r;
    endfunction

    function automatic bit differs(int a);
        logic [DW-1:0] v;
        v = vote(sh[0][a], sh[1][a], sh[2][a]);
        return (sh[0][a] != v) || (sh[1][a] != v) || (sh[2][a] != v);
    endfunction

    function automatic logic [DW-1:0] pat(int i);
        return 32'h5A3C_0000 ^ (32'(i) * 32'h0101_0101) ^ 32'(i << 7);
    endfunction

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // cycle model
    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_mmb = 0; e_rvalid = 0; e_mma = 0;
        end else begin
            bit n_rv;
            n_rv = req && !we;
            if (n_rv) begin
                e_rdata = vote(sh[0][addr], sh[1][addr], sh[2][addr]);
                e_mma   = differs(int'(addr));
            end else e_mma = 0;
            if (m_ph == 0) begin
                if (!req) begin
                    m_sbw = vote(sh[0][m_cnt], sh[1][m_cnt], sh[2][m_cnt]);
                    m_mmb = differs(m_cnt);
                    m_ph = 1;
                end else begin
                    m_cnt = (m_cnt + 1) % D; m_mmb = 0;
                end
            end else begin
                if (!(req && int'(addr) == m_cnt))
                    for (int k = 0; k < 3; k++) sh[k][m_cnt] = m_sbw;
                m_cnt = (m_cnt + 1) % D; m_ph = 0; m_mmb = 0;
            end
            if (req && we) for (int k = 0; k < 3; k++) sh[k][addr] = wdata;
            e_rvalid = n_rv;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(rvalid == e_rvalid, "R3 model rvalid", DW'(rvalid), DW'(e_rvalid));
            if (e_rvalid) check(rdata == e_rdata, "R3 model rdata", rdata, e_rdata);
            if (cmp_en) check(mm == (e_mma || m_mmb), "R4/R8 model mismatch", DW'(mm), DW'(e_mma || m_mmb));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic idle();
        req = 0; we = 0; step();
    endtask

    task automatic rd(int a);
        req = 1; we = 0; addr = AW'(a); step();
    endtask

    task automatic wr(int a, logic [DW-1:0] d);
        req = 1; we = 1; addr = AW'(a); wdata = d; step();
    endtask

    task automatic inject(int cp, int a, logic [DW-1:0] mask);
        sh[cp][a] = sh[cp][a] ^ mask;
        case (cp)
            0: dut_i.g_bank[0].u_bank.mem[a] = sh[0][a];
            1: dut_i.g_bank[1].u_bank.mem[a] = sh[1][a];
            default: dut_i.g_bank[2].u_bank.mem[a] = sh[2][a];
        endcase
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int pulses;
        for (int k = 0; k < 3; k++) for (int i = 0; i < D; i++) sh[k][i] = '0;
        req = 1; we = 1; addr = '0; wdata = pat(0);
        repeat (3) @(negedge clk);
        #1;
        check(rvalid == 0, "R1 reset rvalid", DW'(rvalid), 0);
        check(mm == 0, "R1 reset mismatch", DW'(mm), 0);
        rst = 0;
        // R2: initialise all copies through the user port, scrubber stalled
        for (int i = 0; i < D; i++) wr(i, pat(i));
        check(rvalid == 0, "R1 rvalid after writes", DW'(rvalid), 0);
        cmp_en = 1;
        for (int i = 0; i < PASS_CYC; i++) idle();
        // R3: plain reads
        for (int i = 0; i < D; i += 5) begin
            rd(i);
            check(rvalid == 1, "R3 rvalid", DW'(rvalid), 1);
            check(rdata == pat(i), "R3 rdata", rdata, pat(i));
            check(mm == 0, "R2 clean copies", DW'(mm), 0);
        end
        // R4: single-copy upsets, two slices
        inject(1, 7, 32'h0010_0008);
        rd(7);
        check(rdata == pat(7), "R3 voted over upset", rdata, pat(7));
        check(mm == 1, "R4 mismatch on read", DW'(mm), 1);
        inject(0, 9, 32'h0000_0001);
        inject(2, 9, 32'h8000_0000);
        rd(9);
        check(rdata == pat(9), "R3 two copies different slices", rdata, pat(9));
        check(mm == 1, "R4 mismatch two copies", DW'(mm), 1);
        // R6: continuous traffic, scrubber never gets a slot
        for (int i = 0; i < 3 * D; i++) rd(20 + (i % 4));
        rd(7);
        check(mm == 1, "R6 fault kept under traffic", DW'(mm), 1);
        // R9, R5: one idle pass repairs everything
        for (int i = 0; i < PASS_CYC; i++) idle();
        rd(7);
        check(mm == 0, "R9 addr 7 repaired", DW'(mm), 0);
        check(rdata == pat(7), "R5 repaired data", rdata, pat(7));
        rd(9);
        check(mm == 0, "R9 addr 9 repaired", DW'(mm), 0);
        // R8: scrub compare pulses exactly once per pass for one fault
        inject(2, 12, 32'h0000_4000);
        pulses = 0;
        for (int i = 0; i < PASS_CYC; i++) begin
            idle();
            if (mm) pulses++;
        end
        check(pulses == 1, "R8 scrub mismatch pulses", DW'(pulses), 1);
        // R7: user read during pending write-back cancels it
        inject(0, 17, 32'h0000_0200);
        while (!(m_ph == 1 && m_cnt == 17)) idle();
        rd(17);
        check(mm == 1, "R7 read during write cycle", DW'(mm), 1);
        rd(17);
        check(mm == 1, "R7 write-back cancelled", DW'(mm), 1);
        check(rdata == pat(17), "R7 voted data", rdata, pat(17));
        // R7: user write in the write cycle keeps its own data
        inject(2, 3, 32'h0100_0000);
        while (!(m_ph == 1 && m_cnt == 3)) idle();
        wr(3, 32'hDEAD_BEEF);
        rd(3);
        check(rdata == 32'hDEAD_BEEF, "R7 user write wins", rdata, 32'hDEAD_BEEF);
        check(mm == 0, "R2 write refreshes all copies", DW'(mm), 0);
        for (int i = 0; i < PASS_CYC; i++) idle();
        rd(17);
        check(mm == 0, "R9 later pass repairs 17", DW'(mm), 0);
        idle();
        finish_run();
    end
endmodule